// File: doc/BRIEF.md
# Flash Programming Controller

This block connects a byte-wide data-space bus to a word-organised flash array, which is modelled here as a register array of 16-bit words. A bus read returns one byte of a stored word. Bus writes to the code section go into a four-byte staging buffer. When the fourth byte arrives in the correct order, an aligned pair of words is programmed. Programming can only clear bits, so the new data is ANDed into the stored word.

A separate command port arms the whole-section erase. When the command register holds the chip-erase code, the next high-byte write into the code section is a dummy write. That write starts an erase of every code word. The lock byte is restored to its erased value only after the code section has been wiped. A `busy` flag is high for the whole of a programming or erase run. While `busy` is high, code reads return 0xFF and set a sticky error flag, and buffer writes are dropped.

The address is split into fields from the top down. The two top bits select a section: code, lock byte, protected information bytes, or unmapped space. Below them come the page number and then the word within the page. Bit 0 selects the low or high byte of the word.

Top module: `flashProgCtl`

## Requirements
- R1: A read (`busSel`=1, `busWe`=0) raises `rdValid` in the following cycle, and `busRdata` then carries the addressed byte. For a code word, address bit 0 = 0 returns bits 7:0 and bit 0 = 1 returns bits 15:8.
- R2: After reset, every code byte reads 0xFF, the lock byte reads `LOCK_INIT`, and both `busy` and `readErr` are 0.
- R3: Code writes fill the buffer in the order low then high for the first word, and low then high for the second word. The first byte fixes the pair base as its word index with bit 0 cleared. The fourth byte starts programming with no other command. `busy` then stays high for `PROG_CYCLES` cycles, after which both words hold the new data.
- R4: Programming ANDs the buffered data into the existing word, so a bit that is already 0 stays 0.
- R5: A code write whose address bit 0 does not match the expected byte position empties the buffer. That write stores nothing and starts nothing.
- R6: With command code 0x10 held, a write to a code address with bit 0 = 1 starts an erase that sets every code word to 0xFFFF. `busy` stays high for `ERASE_CYCLES`+1 cycles, and the command then reverts to 0x00. A code write with bit 0 = 0 while 0x10 is held is ignored.
- R7: The lock byte becomes 0xFF only in the last erase cycle, after the code wipe. Reads of the lock byte during the erase return the old value. The information bytes, which read `INFO_SEED`+index, never change.
- R8: A code read while `busy` is high returns 0xFF and sets `readErr`. `readErr` stays set until reset.
- R9: A code write or command write while `busy` is high is ignored and leaves the buffer fill position unchanged.
- R10: A command write with a value other than 0x00 or 0x10 sets the command to 0x00 and empties the buffer.
- R11: Writes to the lock, information or unmapped sections change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address: section, page, word, byte |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after the read |
| cmdWe | input | 1 | Command register write strobe |
| cmdData | input | 8 | Command code (0x00 no-op, 0x10 chip erase) |
| busy | output | 1 | Programming or erase in progress |
| readErr | output | 1 | Sticky: a code read was attempted while busy |

## Verification
The bench builds the block with 4 pages of 4 words, `PROG_CYCLES`=3 and `ERASE_CYCLES`=5. These values make the whole code section small enough to check word by word after an erase. They also keep every busy window only a few cycles long. Reads of the lock byte can therefore land in each phase of the erase, including its final lock-restore cycle. Short runs also allow several program passes over the same pair to test the AND behaviour. A cycle-level reference model is compared with the outputs on every clock.

// File: rtl/flashProgPkg.sv
package flashProgPkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PROG  = 2'd1,
    PH_ERASE = 2'd2,
    PH_LOCK  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SEC_CODE = 2'b00,
    SEC_LOCK = 2'b01,
    SEC_INFO = 2'b10,
    SEC_NONE = 2'b11
  } section_e;

  localparam logic [7:0] CMD_NOP        = 8'h00;
  localparam logic [7:0] CMD_CHIP_ERASE = 8'h10;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic storeByte;   // latch busWdata into buffer slot fillIdx
    logic firstByte;   // capture the pair base from this write
    logic commitProg;  // AND buffer into the addressed pair
    logic wipeCode;    // set every code word to all ones
    logic wipeLock;    // restore the lock byte to all ones
  } nvmStrobe_t;

endpackage

// File: rtl/flashProgCtrl.sv
module flashProgCtrl
  import flashProgPkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWe,
  input  logic       byteHi,
  input  section_e   section,
  input  logic       cmdWe,
  input  logic [7:0] cmdData,
  output nvmStrobe_t strobe,
  output logic [1:0] fillIdx,
  output logic       busy
);

  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       cmdReg;
  logic [1:0]       fill;

  logic idle, codeWrite, ceArmed, orderOk, fillWrite, startErase;
  logic lastByte, cmdAccept, cmdValid, clearFill;

  always_comb begin
    idle       = (phase == PH_IDLE);
    codeWrite  = busSel && busWe && (section == SEC_CODE) && idle;
    ceArmed    = (cmdReg == CMD_CHIP_ERASE);
    orderOk    = (byteHi == fill[0]);
    startErase = codeWrite && ceArmed && byteHi;
    fillWrite  = codeWrite && !ceArmed;
    cmdAccept  = cmdWe && idle;
    cmdValid   = (cmdData == CMD_NOP) || (cmdData == CMD_CHIP_ERASE);

    strobe            = '0;
    strobe.storeByte  = fillWrite && orderOk;
    strobe.firstByte  = fillWrite && orderOk && (fill == 2'd0);
    strobe.commitProg = (phase == PH_PROG) && (cnt == '0);
    strobe.wipeCode   = (phase == PH_ERASE) && (cnt == '0);
    strobe.wipeLock   = (phase == PH_LOCK);

    lastByte  = strobe.storeByte && (fill == 2'd3);
    clearFill = (fillWrite && !orderOk) || (cmdAccept && !cmdValid) || startErase;
  end

  assign fillIdx = fill;
  assign busy    = !idle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill   <= 2'd0;
      cmdReg <= CMD_NOP;
      phase  <= PH_IDLE;
      cnt    <= '0;
    end else begin
      if (clearFill)             fill <= 2'd0;
      else if (strobe.storeByte) fill <= fill + 2'd1;

      if (cmdAccept)       cmdReg <= cmdValid ? cmdData : CMD_NOP;
      else if (startErase) cmdReg <= CMD_NOP;

      unique case (phase)
        PH_IDLE: begin
          if (lastByte) begin
            phase <= PH_PROG;
            cnt   <= CNT_W'(PROG_CYCLES - 1);
          end else if (startErase) begin
            phase <= PH_ERASE;
            cnt   <= CNT_W'(ERASE_CYCLES - 1);
          end
        end
        PH_PROG: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        PH_ERASE: begin
          if (cnt == '0) phase <= PH_LOCK;
          else           cnt   <= cnt - 1'b1;
        end
        PH_LOCK: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flashProgData.sv
module flashProgData
  import flashProgPkg::*;
#(
  parameter int         PAGES          = 8,
  parameter int         WORDS_PER_PAGE = 4,
  parameter int         INFO_BYTES     = 4,
  parameter logic [7:0] INFO_SEED      = 8'h5A,
  parameter logic [7:0] LOCK_INIT      = 8'hFC,
  parameter int         ADDR_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvmStrobe_t        strobe,
  input  logic [1:0]        fillIdx,
  input  logic              busy,
  input  section_e          section,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              rdValid,
  output logic              readErr
);

  localparam int WORD_BITS = $clog2(WORDS_PER_PAGE);
  localparam int PAGE_BITS = $clog2(PAGES);
  localparam int WIDX_W    = WORD_BITS + PAGE_BITS;
  localparam int NUM_WORDS = PAGES * WORDS_PER_PAGE;
  localparam int INFO_AW   = $clog2(INFO_BYTES);

  logic [15:0]       mem [NUM_WORDS];
  logic [7:0]        bufB [4];
  logic [WIDX_W-1:0] base;
  logic [7:0]        lockByte;

  logic [PAGE_BITS-1:0] pageNum;
  logic [WORD_BITS-1:0] wordNum;
  logic [WIDX_W-1:0]    wordIdx;
  logic [15:0]          curWord;
  logic                 readNow;

  assign pageNum = busAddr[WIDX_W:WORD_BITS+1];
  assign wordNum = busAddr[WORD_BITS:1];
  assign wordIdx = {pageNum, wordNum};
  assign curWord = mem[wordIdx];
  assign readNow = busSel && !busWe;

  // Staging buffer and pair base
  always_ff @(posedge clk) begin
    if (!rstN) begin
      base <= '0;
      for (int k = 0; k < 4; k++) bufB[k] <= 8'h00;
    end else if (strobe.storeByte) begin
      bufB[fillIdx] <= busWdata;
      if (strobe.firstByte) base <= {wordIdx[WIDX_W-1:1], 1'b0};
    end
  end

  // Code array: program ANDs, erase sets to ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= 16'hFFFF;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (strobe.wipeCode)
          mem[i] <= 16'hFFFF;
        else if (strobe.commitProg && ((WIDX_W'(i) >> 1) == (base >> 1)))
          mem[i] <= mem[i] & ((i % 2 == 1) ? {bufB[3], bufB[2]} : {bufB[1], bufB[0]});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               lockByte <= LOCK_INIT;
    else if (strobe.wipeLock) lockByte <= 8'hFF;
  end

  // Registered byte read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= 8'h00;
      rdValid  <= 1'b0;
      readErr  <= 1'b0;
    end else begin
      rdValid <= readNow;
      if (readNow) begin
        unique case (section)
          SEC_CODE: begin
            if (busy) begin
              busRdata <= 8'hFF;
              readErr  <= 1'b1;
            end else begin
              busRdata <= busAddr[0] ? curWord[15:8] : curWord[7:0];
            end
          end
          SEC_LOCK: busRdata <= lockByte;
          SEC_INFO: busRdata <= INFO_SEED + 8'(busAddr[INFO_AW-1:0]);
          default:  busRdata <= 8'hFF;
        endcase
      end
    end
  end

endmodule

// File: rtl/flashProgCtl.sv
module flashProgCtl
  import flashProgPkg::*;
#(
  parameter int         PAGES          = 8,
  parameter int         WORDS_PER_PAGE = 4,
  parameter int         PROG_CYCLES    = 8,
  parameter int         ERASE_CYCLES   = 32,
  parameter int         INFO_BYTES     = 4,
  parameter logic [7:0] INFO_SEED      = 8'h5A,
  parameter logic [7:0] LOCK_INIT      = 8'hFC,
  parameter int         ADDR_W         = 3 + $clog2(WORDS_PER_PAGE) + $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              rdValid,
  input  logic              cmdWe,
  input  logic [7:0]        cmdData,
  output logic              busy,
  output logic              readErr
);

  section_e   secSel;
  nvmStrobe_t strobe;
  logic [1:0] fillIdx;

  assign secSel = section_e'(busAddr[ADDR_W-1 -: 2]);

  flashProgCtrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busSel (busSel),
    .busWe  (busWe),
    .byteHi (busAddr[0]),
    .section(secSel),
    .cmdWe  (cmdWe),
    .cmdData(cmdData),
    .strobe (strobe),
    .fillIdx(fillIdx),
    .busy   (busy)
  );

  flashProgData #(
    .PAGES         (PAGES),
    .WORDS_PER_PAGE(WORDS_PER_PAGE),
    .INFO_BYTES    (INFO_BYTES),
    .INFO_SEED     (INFO_SEED),
    .LOCK_INIT     (LOCK_INIT),
    .ADDR_W        (ADDR_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fillIdx (fillIdx),
    .busy    (busy),
    .section (secSel),
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .rdValid (rdValid),
    .readErr (readErr)
  );

endmodule

// File: rtl/flashProgChk.sv
module flashProgChk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busRdata,
  input logic              rdValid,
  input logic              busy,
  input logic              readErr
);

  // R1
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe) |=> rdValid);

  // R1
  rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWe) |=> !rdValid);

  // R8
  busy_read_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && (busAddr[ADDR_W-1 -: 2] == 2'b00) && busy)
      |=> (busRdata == 8'hFF) && readErr);

  // R8
  read_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    readErr |=> readErr);

  // R3
  busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busSel && busWe));

endmodule

bind flashProgCtl flashProgChk #(.ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .rdValid (rdValid),
  .busy    (busy),
  .readErr (readErr)
);

// File: tb/flashProgCtl_bench.sv
module flashProgCtl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PAGES = 4;
  localparam int WPP = 4;
  localparam int PROG_C = 3;
  localparam int ERASE_C = 5;
  localparam int AW = 7;
  localparam int NW = PAGES * WPP;
  localparam logic [7:0] SEED = 8'h5A;
  localparam logic [7:0] LOCK0 = 8'hFC;
  localparam logic [6:0] LOCK_ADDR = 7'h20;
  localparam logic [6:0] INFO_ADDR = 7'h40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0, cmdWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0] busWdata = 8'h00, cmdData = 8'h00;
  logic [7:0] busRdata;
  logic rdValid, busy, readErr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string curReq = "R2";

  always #(CLK_PERIOD / 2) clk = ~clk;

  flashProgCtl #(
    .PAGES(PAGES), .WORDS_PER_PAGE(WPP), .PROG_CYCLES(PROG_C),
    .ERASE_CYCLES(ERASE_C), .INFO_SEED(SEED), .LOCK_INIT(LOCK0)
  ) u_flashProgCtl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rdValid(rdValid),
    .cmdWe(cmdWe), .cmdData(cmdData), .busy(busy), .readErr(readErr)
  );

  // Behavioural reference model
  int mMem[NW];
  int mBuf[4];
  int mBase, mFill, mPhase, mRem, mCmd, mLock, mRd;
  bit mErr, mRdV;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 'hFFFF;
      foreach (mBuf[i]) mBuf[i] = 0;
      mBase = 0; mFill = 0; mPhase = 0; mRem = 0; mCmd = 0;
      mLock = LOCK0; mRd = 0; mErr = 0; mRdV = 0;
    end else begin
      int sec, widx, hi;
      bit wasBusy;
      sec = int'(busAddr) >> 5;
      widx = (int'(busAddr) >> 1) & (NW - 1);
      hi = int'(busAddr) & 1;
      wasBusy = (mPhase != 0);
      mRdV = busSel && !busWe;
      if (mRdV) begin
        case (sec)
          0: if (wasBusy) begin mRd = 'hFF; mErr = 1; end
             else mRd = hi ? (mMem[widx] >> 8) & 'hFF : mMem[widx] & 'hFF;
          1: mRd = mLock;
          2: mRd = (SEED + (int'(busAddr) & 3)) & 'hFF;
          default: mRd = 'hFF;
        endcase
      end
      if (mPhase == 1) begin
        if (mRem == 0) begin
          mMem[mBase] &= (mBuf[1] << 8) | mBuf[0];
          mMem[mBase + 1] &= (mBuf[3] << 8) | mBuf[2];
          mPhase = 0;
        end else mRem--;
      end else if (mPhase == 2) begin
        if (mRem == 0) begin
          foreach (mMem[i]) mMem[i] = 'hFFFF;
          mPhase = 3;
        end else mRem--;
      end else if (mPhase == 3) begin
        mLock = 'hFF; mPhase = 0;
      end else begin
        if (cmdWe) begin
          if (cmdData == 8'h00 || cmdData == 8'h10) mCmd = cmdData;
          else begin mCmd = 0; mFill = 0; end
        end
        if (busSel && busWe && sec == 0) begin
          if (mCmd == 'h10) begin
            if (hi == 1) begin
              mPhase = 2; mRem = ERASE_C - 1; mCmd = 0; mFill = 0;
            end
          end else if (hi != (mFill & 1)) mFill = 0;
          else begin
            if (mFill == 0) mBase = widx & ~1;
            mBuf[mFill] = busWdata;
            mFill++;
            if (mFill == 4) begin mFill = 0; mPhase = 1; mRem = PROG_C - 1; end
          end
        end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (busy !== (mPhase != 0)) begin
        failures++;
        $display("FAIL %s busy act=%0b exp=%0b", curReq, busy, mPhase != 0);
      end
      checks++;
      if (rdValid !== mRdV || readErr !== mErr) begin
        failures++;
        $display("FAIL %s rdValid/readErr act=%0b/%0b exp=%0b/%0b",
                 curReq, rdValid, readErr, mRdV, mErr);
      end
      if (mRdV) begin
        checks++;
        if (busRdata !== 8'(mRd)) begin
          failures++;
          $display("FAIL %s busRdata act=%02h exp=%02h", curReq, busRdata, 8'(mRd));
        end
      end
    end
  end

  function automatic logic [6:0] codeAddr(int page, int word, int hi);
    return 7'((page << 3) | (word << 1) | hi);
  endfunction

  task automatic busWrite(logic [6:0] a, logic [7:0] d);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic cmdWrite(logic [7:0] d);
    cmdWe = 1; cmdData = d;
    @(negedge clk);
    cmdWe = 0;
  endtask

  task automatic readCheck(logic [6:0] a, logic [7:0] exp, string tag);
    busSel = 1; busWe = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    checks++;
    if (!rdValid || busRdata !== exp) begin
      failures++;
      $display("FAIL %s read @%02h act=%02h exp=%02h", tag, a, busRdata, exp);
    end
  endtask

  task automatic flagCheck(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s flag act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 100 && busy; n++) @(negedge clk);
  endtask

  task automatic writePair(int page, int word, logic [7:0] b0, logic [7:0] b1,
                           logic [7:0] b2, logic [7:0] b3);
    busWrite(codeAddr(page, word, 0), b0);
    busWrite(codeAddr(page, word, 1), b1);
    busWrite(codeAddr(page, word + 1, 0), b2);
    busWrite(codeAddr(page, word + 1, 1), b3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R2: reset state
    curReq = "R2";
    flagCheck(busy, 0, "R2");
    flagCheck(readErr, 0, "R2");
    readCheck(codeAddr(0, 0, 0), 8'hFF, "R2");
    readCheck(codeAddr(3, 3, 1), 8'hFF, "R2");
    readCheck(LOCK_ADDR, LOCK0, "R2");

    // R3 / R1: ordered fill programs a pair
    curReq = "R3";
    writePair(1, 2, 8'h34, 8'h12, 8'h78, 8'h56);
    flagCheck(busy, 1, "R3");
    // R8: read while busy
    curReq = "R8";
    readCheck(codeAddr(1, 2, 0), 8'hFF, "R8");
    flagCheck(readErr, 1, "R8");
    // R9: write while busy is dropped
    curReq = "R9";
    busWrite(codeAddr(0, 0, 0), 8'h00);
    waitIdle();
    curReq = "R1";
    readCheck(codeAddr(1, 2, 0), 8'h34, "R1");
    readCheck(codeAddr(1, 2, 1), 8'h12, "R1");
    readCheck(codeAddr(1, 3, 0), 8'h78, "R3");
    readCheck(codeAddr(1, 3, 1), 8'h56, "R3");

    // R4 (also R9: fill position was untouched by the busy write)
    curReq = "R4";
    writePair(1, 2, 8'hF0, 8'h0F, 8'hFF, 8'h00);
    waitIdle();
    readCheck(codeAddr(1, 2, 0), 8'h30, "R4");
    readCheck(codeAddr(1, 2, 1), 8'h02, "R4");
    readCheck(codeAddr(1, 3, 0), 8'h78, "R4");
    readCheck(codeAddr(1, 3, 1), 8'h00, "R9");

    // R5: out-of-order bytes
    curReq = "R5";
    busWrite(codeAddr(0, 0, 0), 8'h00);
    busWrite(codeAddr(0, 0, 0), 8'h00);
    busWrite(codeAddr(0, 0, 1), 8'h00);
    busWrite(codeAddr(0, 1, 1), 8'h00);
    @(negedge clk);
    flagCheck(busy, 0, "R5");
    readCheck(codeAddr(0, 0, 0), 8'hFF, "R5");
    readCheck(codeAddr(0, 1, 1), 8'hFF, "R5");

    // R10: invalid command empties the buffer
    curReq = "R10";
    busWrite(codeAddr(0, 0, 0), 8'h11);
    busWrite(codeAddr(0, 0, 1), 8'h22);
    cmdWrite(8'h33);
    writePair(0, 0, 8'h11, 8'h22, 8'h33, 8'h44);
    waitIdle();
    readCheck(codeAddr(0, 0, 0), 8'h11, "R10");
    readCheck(codeAddr(0, 1, 0), 8'h33, "R10");
    readCheck(codeAddr(0, 1, 1), 8'h44, "R10");

    // R11: protected sections ignore writes
    curReq = "R11";
    busWrite(LOCK_ADDR, 8'h00);
    busWrite(INFO_ADDR + 7'd2, 8'h00);
    busWrite(7'h60, 8'h00);
    @(negedge clk);
    flagCheck(busy, 0, "R11");
    readCheck(LOCK_ADDR, LOCK0, "R11");
    readCheck(INFO_ADDR + 7'd2, SEED + 8'd2, "R11");

    // R6 / R7: chip erase
    curReq = "R6";
    cmdWrite(8'h10);
    busWrite(codeAddr(2, 1, 0), 8'h00);
    @(negedge clk);
    flagCheck(busy, 0, "R6");
    busWrite(codeAddr(2, 1, 1), 8'h00);
    flagCheck(busy, 1, "R6");
    curReq = "R7";
    for (int k = 0; k < ERASE_C; k++) begin
      if (!busy) break;
      readCheck(LOCK_ADDR, LOCK0, "R7");
    end
    waitIdle();
    readCheck(LOCK_ADDR, 8'hFF, "R7");
    readCheck(INFO_ADDR + 7'd1, SEED + 8'd1, "R7");
    curReq = "R6";
    for (int w = 0; w < NW; w++) begin
      readCheck(7'(w << 1), 8'hFF, "R6");
      readCheck(7'((w << 1) | 1), 8'hFF, "R6");
    end
    // command reverted: a fill programs again
    writePair(3, 0, 8'hA5, 8'h5A, 8'h0F, 8'hF0);
    waitIdle();
    readCheck(codeAddr(3, 0, 1), 8'h5A, "R6");
    readCheck(codeAddr(3, 1, 0), 8'h0F, "R6");
    flagCheck(readErr, 1, "R8");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule